// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block converts single-byte host requests into the pin activity of a NAND flash bus. A request names a window (command, address or data), a direction and, for writes, a byte. The block drives the chip enables, the command and address latch enables, the write and read strobes and the output enable of the bidirectional data bus. On reads it captures the byte the flash returns.

Each access moves through a fixed sequence of phases: setup, an optional read gap, strobe and hold. Every phase length comes from its own timing input, counted in system clock cycles. The timing inputs and the bank select are sampled once, when a request is accepted. An active-low wait input from the flash keeps the strobe asserted for longer. A done pulse ends each access, and on reads it carries the captured byte. The host can then issue the next request.

Top module: `nand_pin_sequencer`

## Requirements
- R1: During and after a synchronous reset, and with no request accepted yet: req_ready=1, done=0, every nand_ce_n bit is 1, nand_cle=0, nand_ale=0, nand_we_n=1, nand_re_n=1 and nand_dq_oe=0.
- R2: req_win encoding is 0=command, 1=address, 2=data (3 behaves as data). For a whole access, nand_cle=1 only for window 0 and nand_ale=1 only for window 1. Only nand_ce_n[req_bank] is low and the other three bits stay high. The strobe that does not match the direction stays high.
- R3: Chip enable is active for cfg_setup+1 cycles before the strobe falls. This holds for writes and for reads that get no gap.
- R4: A read adds a gap before nand_re_n falls. The gap depends on the window of the previously accepted request: cfg_cle_re+1 cycles after window 0, cfg_ale_re+1 cycles after window 1, and no gap after a data window or when no request has been accepted since reset.
- R5: The strobe (nand_we_n for req_wr=1, nand_re_n for req_wr=0) stays low for cfg_strobe+1 cycles. While nand_wait_n is low it stays low longer and ends in the first cycle where the count is used up and nand_wait_n is high. The two strobes are never low together.
- R6: After the strobe rises, chip enable, the latch enable and the write data stay for cfg_hold+1 cycles.
- R7: On a write, nand_dq_oe is low for the first cfg_hiz cycles of the access (0 gives 0 cycles) and then high until the access ends, with nand_dq_out equal to the write byte. On a read, nand_dq_oe stays low whatever cfg_hiz holds.
- R8: On a read, rdata holds the nand_dq_in value of the last strobe cycle and is valid while done is high.
- R9: done is a one-cycle pulse in the cycle after the last hold cycle. req_ready is low from the cycle after acceptance until that cycle.
- R10: The timing inputs, req_win, req_wr, req_bank and req_wdata are sampled only at acceptance. Changing them during an access has no effect on that access.
- R11: A reset during an access abandons it, returns the pins to the R1 state and forgets the previous window, so that the next read has no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_win | input | 2 | Window: 0 command, 1 address, 2 data |
| req_wr | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Chip enable select |
| req_wdata | input | DATA_W | Write byte |
| done | output | 1 | Access finished pulse |
| rdata | output | DATA_W | Captured read byte |
| cfg_setup | input | 8 | Setup length minus one |
| cfg_strobe | input | 8 | Strobe length minus one |
| cfg_hold | input | 8 | Hold length minus one |
| cfg_hiz | input | 8 | Write bus float cycles |
| cfg_cle_re | input | 4 | Gap after command, minus one |
| cfg_ale_re | input | 4 | Gap after address, minus one |
| nand_wait_n | input | 1 | Flash wait, low stretches strobe |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DATA_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DATA_W | Data bus input value |

## Verification
The read gap is the hardest behaviour to reach from the ports. It depends on the window of the request before, so one request cannot exercise it. The stimulus table is therefore ordered as a chain in which each read follows a command write, an address write, a data access or a reset. The bench also holds the wait input low for a chosen number of strobe cycles, so that the strobe stretches past its count. It overwrites every timing input and request field just after acceptance to show that only the sampled values count.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int TIME_W = 8;
    localparam int GAP_W  = 4;
    localparam int BANK_W = 2;
    localparam int NUM_CE = 1 << BANK_W;

    typedef enum logic [1:0] {
        WIN_CMD  = 2'd0,
        WIN_ADDR = 2'd1,
        WIN_DATA = 2'd2
    } win_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_GAP    = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_e;

    typedef struct packed {
        win_e              win;
        logic              wr;
        logic [BANK_W-1:0] bank;
    } acc_t;

    // A read needs a gap only when the previous access raised a latch enable.
    function automatic logic gap_needed(input win_e prev);
        return (prev == WIN_CMD) || (prev == WIN_ADDR);
    endfunction

    function automatic logic [TIME_W-1:0] gap_count(input win_e prev,
                                                    input logic [GAP_W-1:0] cle_re,
                                                    input logic [GAP_W-1:0] ale_re);
        logic [GAP_W-1:0] sel;
        sel = (prev == WIN_CMD) ? cle_re : ale_re;
        return {{(TIME_W-GAP_W){1'b0}}, sel};
    endfunction

    // Requests outside the defined codes are treated as data accesses.
    function automatic win_e decode_win(input logic [1:0] code);
        win_e w;
        case (code)
            2'd0:    w = WIN_CMD;
            2'd1:    w = WIN_ADDR;
            default: w = WIN_DATA;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/nseq_hiz_timer.sv
module nseq_hiz_timer
    import nseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TIME_W-1:0] hiz_in,
    output logic              expired
);
    logic [TIME_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= hiz_in;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired = (left_q == '0);

endmodule

// File: rtl/nseq_phase_ctrl.sv
module nseq_phase_ctrl
    import nseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_win,
    input  logic              req_wr,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TIME_W-1:0] cfg_setup,
    input  logic [TIME_W-1:0] cfg_strobe,
    input  logic [TIME_W-1:0] cfg_hold,
    input  logic [GAP_W-1:0]  cfg_cle_re,
    input  logic [GAP_W-1:0]  cfg_ale_re,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] dq_in,
    output phase_e            phase,
    output acc_t              cur,
    output logic [DATA_W-1:0] wdata_q,
    output logic              accept,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W-1:0] strobe_q;
    logic [TIME_W-1:0] hold_q;
    logic [TIME_W-1:0] gap_q;
    logic              gap_en_q;
    win_e              prev_win_q;
    win_e              new_win;
    logic              cnt_zero;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign new_win   = decode_win(req_win);
    assign cnt_zero  = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt_q      <= '0;
            strobe_q   <= '0;
            hold_q     <= '0;
            gap_q      <= '0;
            gap_en_q   <= 1'b0;
            prev_win_q <= WIN_DATA;
            cur        <= '{win: WIN_DATA, wr: 1'b0, bank: '0};
            wdata_q    <= '0;
            done       <= 1'b0;
            rdata      <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur        <= '{win: new_win, wr: req_wr, bank: req_bank};
                        wdata_q    <= req_wdata;
                        strobe_q   <= cfg_strobe;
                        hold_q     <= cfg_hold;
                        gap_en_q   <= !req_wr && gap_needed(prev_win_q);
                        gap_q      <= gap_count(prev_win_q, cfg_cle_re, cfg_ale_re);
                        prev_win_q <= new_win;
                        cnt_q      <= cfg_setup;
                        phase      <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (gap_en_q) begin
                        cnt_q <= gap_q;
                        phase <= PH_GAP;
                    end else begin
                        cnt_q <= strobe_q;
                        phase <= PH_STROBE;
                    end
                end
                PH_GAP: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        cnt_q <= strobe_q;
                        phase <= PH_STROBE;
                    end
                end
                PH_STROBE: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (wait_n) begin
                        if (!cur.wr) begin
                            rdata <= dq_in;
                        end
                        cnt_q <= hold_q;
                        phase <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (!cnt_zero) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5: a low wait input keeps the strobe phase alive for another cycle
    a_r5_wait_stretch: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && !wait_n) |=> (phase == PH_STROBE));

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done coincides with readiness for the next request
    a_r9_done_ready: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

endmodule

// File: rtl/nseq_pin_drv.sv
module nseq_pin_drv
    import nseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  acc_t              cur,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              hiz_expired,
    output logic [NUM_CE-1:0] ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic busy;
    logic strobing;

    assign busy     = (phase != PH_IDLE);
    assign strobing = (phase == PH_STROBE);

    for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
        assign ce_n[i] = !(busy && (cur.bank == BANK_W'(i)));
    end

    assign cle    = busy && (cur.win == WIN_CMD);
    assign ale    = busy && (cur.win == WIN_ADDR);
    assign we_n   = !(strobing && cur.wr);
    assign re_n   = !(strobing && !cur.wr);
    assign dq_oe  = busy && cur.wr && hiz_expired;
    assign dq_out = dq_oe ? wdata_q : '0;

endmodule

// File: rtl/nand_pin_sequencer.sv
module nand_pin_sequencer
    import nseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_win,
    input  logic              req_wr,
    input  logic [1:0]        req_bank,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic [7:0]        cfg_setup,
    input  logic [7:0]        cfg_strobe,
    input  logic [7:0]        cfg_hold,
    input  logic [7:0]        cfg_hiz,
    input  logic [3:0]        cfg_cle_re,
    input  logic [3:0]        cfg_ale_re,
    input  logic              nand_wait_n,
    output logic [3:0]        nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in
);
    phase_e            phase;
    acc_t              cur;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;
    logic              hiz_expired;

    nseq_phase_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_win    (req_win),
        .req_wr     (req_wr),
        .req_bank   (req_bank),
        .req_wdata  (req_wdata),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .cfg_hold   (cfg_hold),
        .cfg_cle_re (cfg_cle_re),
        .cfg_ale_re (cfg_ale_re),
        .wait_n     (nand_wait_n),
        .dq_in      (nand_dq_in),
        .phase      (phase),
        .cur        (cur),
        .wdata_q    (wdata_q),
        .accept     (accept),
        .done       (done),
        .rdata      (rdata)
    );

    nseq_hiz_timer u_hiz (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .hiz_in  (cfg_hiz),
        .expired (hiz_expired)
    );

    nseq_pin_drv #(.DATA_W(DATA_W)) u_pins (
        .phase       (phase),
        .cur         (cur),
        .wdata_q     (wdata_q),
        .hiz_expired (hiz_expired),
        .ce_n        (nand_ce_n),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .we_n        (nand_we_n),
        .re_n        (nand_re_n),
        .dq_out      (nand_dq_out),
        .dq_oe       (nand_dq_oe)
    );

    // R5: the two strobes are never active together
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R2: at most one chip enable and at most one latch enable active
    a_r2_ce_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~nand_ce_n));
    a_r2_latch_excl: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R7: the bus is never driven while the read strobe is active
    a_r7_read_float: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

    // R1: an idle sequencer leaves every pin inactive
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((&nand_ce_n) && nand_we_n && nand_re_n && !nand_dq_oe));

    // R6: a rising strobe is followed by a hold cycle with chip enable active
    a_r6_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
        ($rose(nand_we_n) || $rose(nand_re_n)) |-> !(&nand_ce_n));

endmodule

// File: tb/nand_pin_sequencer_tb.sv
`timescale 1ns/1ps
module nand_pin_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_win = 2'd2;
    logic       req_wr = 1'b0;
    logic [1:0] req_bank = 2'd0;
    logic [7:0] req_wdata = 8'h00;
    logic       done;
    logic [7:0] rdata;
    logic [7:0] cfg_setup = 8'd0, cfg_strobe = 8'd0, cfg_hold = 8'd0, cfg_hiz = 8'd0;
    logic [3:0] cfg_cle_re = 4'd0, cfg_ale_re = 4'd0;
    logic       nand_wait_n = 1'b1;
    logic [3:0] nand_ce_n;
    logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out;
    logic [7:0] nand_dq_in = 8'h00;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nand_pin_sequencer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_win(req_win), .req_wr(req_wr), .req_bank(req_bank), .req_wdata(req_wdata),
        .done(done), .rdata(rdata),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz),
        .cfg_cle_re(cfg_cle_re), .cfg_ale_re(cfg_ale_re), .nand_wait_n(nand_wait_n),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
    );

    typedef struct packed {
        logic [1:0] win;
        logic       wr;
        logic [7:0] su, wt, ho, hz;
        logic [3:0] cre, are;
        logic [1:0] bank;
        logic [7:0] wd, din, busy;
        logic [7:0] e_pre, e_stb, e_post, e_hz;
    } vec_t;

    // win wr su wt ho hz cre are bank wd din busy | pre stb post hz
    localparam vec_t VEC [11] = '{
        '{2'd2,1'b0,8'd0,8'd0,8'd0,8'd5,4'd3,4'd2,2'd0,8'h00,8'hA5,8'd0, 8'd1, 8'd1,8'd1,8'd0},
        '{2'd0,1'b1,8'd2,8'd1,8'd0,8'd0,4'd0,4'd0,2'd1,8'h70,8'h00,8'd0, 8'd3, 8'd2,8'd1,8'd0},
        '{2'd2,1'b0,8'd1,8'd0,8'd2,8'd0,4'd3,4'd0,2'd1,8'h00,8'h3C,8'd0, 8'd6, 8'd1,8'd3,8'd0},
        '{2'd1,1'b1,8'd0,8'd2,8'd1,8'd2,4'd0,4'd0,2'd2,8'h12,8'h00,8'd2, 8'd1, 8'd3,8'd2,8'd2},
        '{2'd2,1'b0,8'd0,8'd0,8'd0,8'd9,4'd7,4'd5,2'd3,8'h00,8'hC3,8'd4, 8'd7, 8'd4,8'd1,8'd0},
        '{2'd2,1'b0,8'd0,8'd1,8'd0,8'd0,4'd7,4'd5,2'd0,8'h00,8'h5A,8'd0, 8'd1, 8'd2,8'd1,8'd0},
        '{2'd2,1'b1,8'd3,8'd0,8'd3,8'd4,4'd0,4'd0,2'd0,8'hE1,8'h00,8'd0, 8'd4, 8'd1,8'd4,8'd4},
        '{2'd0,1'b1,8'd0,8'd0,8'd0,8'd0,4'd0,4'd0,2'd3,8'hFF,8'h00,8'd0, 8'd1, 8'd1,8'd1,8'd0},
        '{2'd2,1'b0,8'd0,8'd2,8'd1,8'd0,4'd15,4'd0,2'd2,8'h00,8'h81,8'd6, 8'd17,8'd6,8'd2,8'd0},
        '{2'd1,1'b0,8'd1,8'd0,8'd0,8'd0,4'd0,4'd0,2'd1,8'h00,8'h77,8'd0, 8'd2, 8'd1,8'd1,8'd0},
        '{2'd2,1'b0,8'd0,8'd0,8'd0,8'd0,4'd0,4'd9,2'd0,8'h00,8'h0F,8'd0, 8'd11,8'd1,8'd1,8'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req_ready == 1'b1, req, req_ready, 1);
        chk(done == 1'b0, req, done, 0);
        chk(nand_ce_n == 4'hF, req, nand_ce_n, 15);
        chk(nand_cle == 1'b0 && nand_ale == 1'b0, req, {nand_cle, nand_ale}, 0);
        chk(nand_we_n && nand_re_n, req, {nand_we_n, nand_re_n}, 3);
        chk(nand_dq_oe == 1'b0, req, nand_dq_oe, 0);
    endtask

    // Called at a negedge with the sequencer idle; returns at the done negedge.
    task automatic run_vec(input vec_t v);
        int pre = 0, stb = 0, post = 0, nhz = 0, noe = 0;
        int ce_bad = 0, pin_bad = 0, dq_bad = 0, rdy_bad = 0;
        bit seen = 1'b0, got_done = 1'b0;
        logic [7:0] rd = 8'h00;
        logic strobe, other;
        req_win = v.win; req_wr = v.wr; req_bank = v.bank; req_wdata = v.wd;
        cfg_setup = v.su; cfg_strobe = v.wt; cfg_hold = v.ho; cfg_hiz = v.hz;
        cfg_cle_re = v.cre; cfg_ale_re = v.are;
        nand_dq_in = v.din;
        nand_wait_n = (v.busy == 8'd0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R10: scramble every sampled input once the access is running
        req_win = ~v.win; req_wr = ~v.wr; req_bank = ~v.bank; req_wdata = ~v.wd;
        cfg_setup = 8'hE7; cfg_strobe = 8'hD5; cfg_hold = 8'hC9; cfg_hiz = 8'hBB;
        cfg_cle_re = 4'hE; cfg_ale_re = 4'hD;
        for (int cyc = 0; cyc < 2000 && !got_done; cyc++) begin
            if (done) begin
                got_done = 1'b1;
                rd = rdata;
            end else begin
                if (req_ready) rdy_bad++;
                if (nand_ce_n != ~(4'b0001 << v.bank)) ce_bad++;
                if (nand_cle != (v.win == 2'd0) || nand_ale != (v.win == 2'd1)) pin_bad++;
                strobe = v.wr ? !nand_we_n : !nand_re_n;
                other  = v.wr ? !nand_re_n : !nand_we_n;
                if (other) pin_bad++;
                if (strobe) begin
                    stb++;
                    seen = 1'b1;
                    if (stb >= int'(v.busy)) nand_wait_n = 1'b1;
                end else if (seen) begin
                    post++;
                end else begin
                    pre++;
                end
                if (nand_dq_oe) begin
                    noe++;
                    if (nand_dq_out != v.wd) dq_bad++;
                end else begin
                    nhz++;
                end
                @(negedge clk);
            end
        end
        nand_wait_n = 1'b1;
        chk(got_done, "R9", got_done, 1);
        chk(rdy_bad == 0, "R9", rdy_bad, 0);
        chk(ce_bad == 0, "R2", ce_bad, 0);
        chk(pin_bad == 0, "R2", pin_bad, 0);
        chk(pre == int'(v.e_pre), v.wr ? "R3" : "R4", pre, v.e_pre);
        chk(stb == int'(v.e_stb), "R5", stb, v.e_stb);
        chk(post == int'(v.e_post), "R6", post, v.e_post);
        chk(pre + stb + post == int'(v.e_pre) + int'(v.e_stb) + int'(v.e_post),
            "R10", pre + stb + post, v.e_pre + v.e_stb + v.e_post);
        if (v.wr) begin
            chk(nhz == int'(v.e_hz), "R7", nhz, v.e_hz);
            chk(dq_bad == 0, "R7", dq_bad, 0);
        end else begin
            chk(noe == 0, "R7", noe, 0);
            chk(rd == v.din, "R8", rd, v.din);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        vec_t rv;
        // R1: state while reset is held and just after release
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        for (int i = 0; i < 11; i++) begin
            run_vec(VEC[i]);
        end

        // R11: abort a long command write in mid-setup
        req_win = 2'd0; req_wr = 1'b1; req_bank = 2'd2; req_wdata = 8'h44;
        cfg_setup = 8'd20; cfg_strobe = 8'd0; cfg_hold = 8'd0; cfg_hiz = 8'd0;
        cfg_cle_re = 4'd5; cfg_ale_re = 4'd5;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(nand_ce_n == 4'b1011, "R11", nand_ce_n, 11);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R11");
        rst = 1'b0;
        @(negedge clk);
        // The aborted command must not cause a gap: pre stays at setup+1.
        rv = '{2'd2,1'b0,8'd0,8'd0,8'd0,8'd0,4'd5,4'd5,2'd1,8'h00,8'h96,8'd0,
               8'd1,8'd1,8'd1,8'd0};
        run_vec(rv);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule